// File: doc/BRIEF.md
# Scaled Second-Order Sigma-Delta Bitstream Modulator

One channel of a one-bit audio conversion path. The block captures a 20-bit two's complement sample when a one-cycle load strobe is high, and holds it until the next strobe. The held sample goes through a fixed gain of three quarters and then receives a constant positive offset of one eighth of full scale. The result drives a second-order sigma-delta loop with saturating integrators. The loop emits one output bit per modulator-clock tick.

The design runs entirely on the master clock and derives an internal modulator-clock enable. With the half-rate control low, the loop advances on every master cycle and its bit goes straight to the output. With the half-rate control high, the loop advances on every second master cycle. Its bit is then inverted on alternate master cycles (a 1,0 chop at the master rate), which moves the audio band up to high frequency. With the idle control high, the integrators are held at zero and the output toggles on every master cycle. This gives a 50% duty stream that averages to half scale.

Top module: `sdm_bitstream`

## Requirements
- R1: While the asynchronous active-low reset is low, `bitOut` is 0.
- R2: `sampleIn` is captured only on a cycle where `loadStb` is high, and it is held until the next such cycle. Changes on `sampleIn` without a strobe have no effect on the output stream.
- R3: The loop input is u = x - floor(x/4) + 2^16, with x the held signed sample. The feedback reference is ±2^19. At full rate, the fraction of ones in `bitOut` over a long window equals (u + 2^19) / 2^20; for x = 0 this is 9/16.
- R4: The extreme codes 0x80000 and 0x7FFFF are accepted without loop overload and give ones densities of 3/16 and 15/16.
- R5: While `idle` is high, `bitOut` inverts on every master clock.
- R6: `idle` clears both integrators. In the first two master cycles after `idle` falls at full rate with x = 0, the outputs are 1 and then 0.
- R7: With `halfRate` high, the loop advances on every second master cycle. Within each aligned pair of master cycles the output is b and then not b. As a result, any 2N-cycle window holds N ones ±1, and no three consecutive outputs are equal.
- R8: With `halfRate` low, the loop advances on every master cycle and its bit is output without chopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | One-cycle sample load strobe |
| sampleIn | input | 20 | Two's complement sample |
| idle | input | 1 | Idle request: clear the loop and output the half-scale toggle |
| halfRate | input | 1 | Run the loop at half the master rate and chop the output |
| bitOut | output | 1 | One-bit output stream |

## Verification
A strobed sample reaches the holding register one edge later. It then takes a few loop ticks to settle into a steady ones density, so the bench waits 200 master cycles after every change of sample or mode before it counts ones over a 4096-cycle window. The idle toggle and the post-idle bit pattern appear at the first edge after the control changes, so those checks compare every negative-edge sample from the cycle that follows. The chop check counts ones over a window of even length and looks for runs of three. Because either pair alignment is valid, a tolerance of one is allowed.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef struct packed {
    logic modEn;   // loop advance for this master cycle
    logic chop;    // invert output this master cycle
    logic clear;   // hold loop at zero, toggle output
  } sdmCtrl_t;
endpackage

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     idle,
  input  logic     halfRate,
  output sdmCtrl_t ctrl
);
  logic phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= halfRate ? ~phase : 1'b0;
  end

  always_comb begin
    ctrl.modEn = ~halfRate | phase;
    ctrl.chop  = halfRate & phase;
    ctrl.clear = idle;
  end

  // R7: at half rate the loop enable never stays high two cycles in a row
  a_r7_alternate: assert property (@(posedge clk) disable iff (!rstN)
    (halfRate && ctrl.modEn) |=> (!halfRate || !ctrl.modEn));
endmodule

// File: rtl/sdm_datapath.sv
module sdm_datapath
  import sdm_pkg::*;
#(
  parameter int IN_W = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadStb,
  input  logic [IN_W-1:0] sampleIn,
  input  sdmCtrl_t        ctrl,
  output logic            bitOut
);
  localparam int SC_W  = IN_W + 2;
  localparam int INT_W = IN_W + 5;
  localparam int ACC_W = INT_W + 2;
  localparam logic signed [ACC_W-1:0] REF    = ACC_W'(64'sd1 <<< (IN_W - 1));
  localparam logic signed [ACC_W-1:0] OFFSET = ACC_W'(64'sd1 <<< (IN_W - 4));
  localparam logic signed [ACC_W-1:0] SATHI  = ACC_W'((64'sd1 <<< (INT_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SATLO  = ACC_W'(-(64'sd1 <<< (INT_W - 1)));

  logic signed [IN_W-1:0]  heldSample;
  logic signed [SC_W-1:0]  wideSample, scaled;
  logic signed [ACC_W-1:0] loopIn, fb, i1Sum, i2Sum;
  logic signed [INT_W-1:0] i1, i2, i1Next, i2Next;
  logic                    modBit;

  function automatic logic signed [INT_W-1:0] clampInt(input logic signed [ACC_W-1:0] v);
    if (v > SATHI)      return SATHI[INT_W-1:0];
    else if (v < SATLO) return SATLO[INT_W-1:0];
    else                return v[INT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        heldSample <= '0;
    else if (loadStb) heldSample <= sampleIn;
  end

  always_comb begin
    wideSample = SC_W'(heldSample);
    scaled     = wideSample - (wideSample >>> 2);
    loopIn     = ACC_W'(scaled) + OFFSET;
    modBit     = ~i2[INT_W-1];
    fb         = modBit ? REF : -REF;
    i1Sum      = ACC_W'(i1) + loopIn - fb;
    i1Next     = clampInt(i1Sum);
    i2Sum      = ACC_W'(i2) + ACC_W'(i1Next) - fb;
    i2Next     = clampInt(i2Sum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      i1 <= '0;
      i2 <= '0;
    end else if (ctrl.clear) begin
      i1 <= '0;
      i2 <= '0;
    end else if (ctrl.modEn) begin
      i1 <= i1Next;
      i2 <= i2Next;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitOut <= 1'b0;
    else if (ctrl.clear) bitOut <= ~bitOut;
    else                 bitOut <= modBit ^ ctrl.chop;
  end

  // R2: held sample moves only on a strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(heldSample));
  // R6: idle empties both integrators
  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (i1 == '0 && i2 == '0));
  // R8: loop state changes only on a modulator tick
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.modEn && !ctrl.clear) |=> ($stable(i1) && $stable(i2)));
  // R5: idle output inverts every cycle
  a_r5_idle_toggle: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (bitOut != $past(bitOut)));
endmodule

// File: rtl/sdm_bitstream.sv
module sdm_bitstream
  import sdm_pkg::*;
#(
  parameter int IN_W = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadStb,
  input  logic [IN_W-1:0] sampleIn,
  input  logic            idle,
  input  logic            halfRate,
  output logic            bitOut
);
  sdmCtrl_t ctrl;

  sdm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .idle(idle), .halfRate(halfRate), .ctrl(ctrl)
  );

  sdm_datapath #(.IN_W(IN_W)) u_dp (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .sampleIn(sampleIn),
    .ctrl(ctrl), .bitOut(bitOut)
  );

  // R1: output low during reset
  always_comb begin
    if (!rstN) a_r1_reset_low: assert (bitOut == 1'b0);
  end
endmodule

// File: tb/sdm_bitstream_tb.sv
module sdm_bitstream_tb;
  logic clk = 0, rstN = 0, loadStb = 0, idle = 0, halfRate = 0;
  logic [19:0] sampleIn = '0;
  logic bitOut;

  int testsRun = 0, testsFailed = 0;
  int pushed = 0, doneCount = 0;

  typedef struct {
    int    kind;     // 0 density, 1 idle toggle, 2 chop pair
    string req;
    int    expOnes;
    int    tol;
    int    window;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  sdm_bitstream u_dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .sampleIn(sampleIn),
    .idle(idle), .halfRate(halfRate), .bitOut(bitOut)
  );

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    testsRun++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d tol=%0d", req, act, exp, tol);
    end
  endtask

  function automatic int expectOnes(input int x, input int window);
    int u;
    longint num;
    u   = x - (x >>> 2) + 65536;
    num = longint'(window) * longint'(u + 524288) + 64'sd524288;
    return int'(num / 64'sd1048576);
  endfunction

  // monitor: pops expectations and compares against the running output
  initial begin
    forever begin
      item_t it;
      int ones, bad, run;
      logic prev;
      wait (q.size() > 0);
      it = q.pop_front();
      ones = 0; bad = 0; run = 1;
      @(negedge clk);
      prev = bitOut;
      ones += int'(bitOut);
      for (int n = 1; n < it.window; n++) begin
        @(negedge clk);
        ones += int'(bitOut);
        if (it.kind == 1 && bitOut == prev) bad++;
        if (it.kind == 2) begin
          run = (bitOut == prev) ? run + 1 : 1;
          if (run >= 3) bad++;
        end
        prev = bitOut;
      end
      if (it.kind == 0) check(it.req, ones, it.expOnes, it.tol);
      else if (it.kind == 1) check(it.req, bad, 0, 0);
      else begin
        check(it.req, ones, it.expOnes, it.tol);
        check(it.req, bad, 0, 0);
      end
      doneCount++;
    end
  end

  task automatic expect_item(input int kind, input string req, input int expOnes,
                             input int tol, input int window);
    item_t it;
    it.kind = kind; it.req = req; it.expOnes = expOnes; it.tol = tol; it.window = window;
    q.push_back(it);
    pushed++;
    wait (doneCount == pushed);
  endtask

  task automatic load(input int x);
    @(negedge clk);
    sampleIn = 20'(x);
    loadStb  = 1;
    @(negedge clk);
    loadStb  = 0;
    repeat (200) @(negedge clk);
  endtask

  task automatic densityTest(input int x, input string req);
    load(x);
    expect_item(0, req, expectOnes(x, 4096), 24, 4096);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset", int'(bitOut), 0, 0);
    rstN = 1;
    repeat (4) @(negedge clk);

    densityTest(0, "R3 zero input 9/16");
    densityTest(200000, "R3 positive");
    densityTest(-100000, "R8 full rate unchopped");
    densityTest(-524288, "R4 min code");
    densityTest(524287, "R4 max code");
    densityTest(131072, "R3 quarter scale");

    // R2: change input without strobe, density stays that of 131072
    @(negedge clk);
    sampleIn = 20'h80000;
    repeat (200) @(negedge clk);
    expect_item(0, "R2 no strobe ignored", expectOnes(131072, 4096), 24, 4096);

    // R5: idle toggle
    @(negedge clk);
    idle = 1;
    @(negedge clk);
    expect_item(1, "R5 idle toggle", 0, 0, 512);
    expect_item(0, "R5 idle half density", 256, 1, 512);

    // R6: release idle with x = 0 at full rate
    load(0);
    @(negedge clk);
    idle = 0;
    @(negedge clk);
    check("R6 first bit after idle", int'(bitOut), 1, 0);
    @(negedge clk);
    check("R6 second bit after idle", int'(bitOut), 0, 0);
    repeat (200) @(negedge clk);

    // R7: half rate with chop
    halfRate = 1;
    repeat (200) @(negedge clk);
    expect_item(2, "R7 chop x=0", 2048, 1, 4096);
    load(300000);
    expect_item(2, "R7 chop positive", 2048, 1, 4096);
    load(-400000);
    expect_item(2, "R7 chop negative", 2048, 1, 4096);

    // R8: back to full rate, density follows input again
    halfRate = 0;
    densityTest(-200000, "R8 back to full rate");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 5);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule